// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers character frames from one asynchronous serial line. It watches the line for the falling edge that opens a frame. It then samples the start bit, each data bit, an optional parity bit and one stop bit, taking each sample at the centre of its bit cell. The clock-cycles-per-bit divisor, the data width, the bit order, the parity rule, whether parity is checked and the line polarity are all inputs. They can be changed between frames without a reset.

Every sample instant is measured from the single recorded frame-start moment, and each instant is an exact integer. Timing error therefore does not build up over the frame. A start bit that is no longer low at its centre is rejected as a false start. A parity mismatch or a low stop bit is reported, but the frame still runs to its end.

The received word is a valid-only stream. The line cannot be paused, so there is no ready input. The word sits on `rx_data_o` and holds until the next word replaces it, and the consumer must take it in the cycle `rx_valid_o` is high. The error outputs are plain one-cycle pulses.

Top module: `async_frame_rx`

## Requirements
- R1: After reset all strobes are low and `rx_data_o` is zero. The receiver leaves idle only on a falling edge of the line as seen after optional inversion, so a line held low since reset, or a rising edge, starts nothing.
- R2: With divisor P (P ≥ 4), slot n is sampled floor(P/2) + n·P cycles after the cycle in which the start edge is detected. Slot 0 is the start bit and slots 1..N are data. Counting the first clock edge that captures the falling line as edge 1, `rx_valid_o` pulses for one cycle just after edge 3 + floor(P/2) + N·P.
- R3: If the line reads high at the slot-0 sample point, `err_start_o` pulses just after edge 3 + floor(P/2). No word is produced, and the receiver returns to idle ready for the next falling edge.
- R4: `cfg_width_i` gives the data bit count N directly. Values below 5 act as 5 and values above 9 act as 9. The word is right-justified in `rx_data_o` with all bits at and above N zero.
- R5: With `cfg_msb_first_i` = 0 the first data bit received is word bit 0. With 1 it is word bit N−1.
- R6: `cfg_parity_i` encodes 0 none, 1 odd, 2 even, 3 always-zero and 4 always-one, and codes 5 to 7 act as none. Odd requires an odd count of ones over the data and parity bit together. Even requires an even count. Always-zero requires the parity bit to be 0 and always-one requires it to be 1.
- R7: When parity is on and `cfg_parity_check_i` = 1, a failed rule pulses `err_parity_o` one period after the valid strobe. The frame continues to its stop bit and the word is still delivered. With the check off, no parity error is ever signalled.
- R8: A stop bit read as 0 pulses `err_stop_o` at the stop slot. The receiver still returns to idle, and a following frame is received normally.
- R9: With `cfg_invert_i` = 1 the line is complemented before synchronization, edge detection and sampling. The idle level is then low and a rising raw edge opens a frame.
- R10: Width, order, parity mode, parity check and divisor are taken as they stand in the cycle the start edge is detected, and are held for the whole frame. A change during a frame does not affect that frame.
- R11: With parity set to none the stop bit is sampled at slot N+1; otherwise it is sampled at slot N+2. A stop error pulses just after edge 3 + floor(P/2) + slot·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, asynchronous to the clock |
| cfg_period_i | input | PERIOD_W | Clock cycles per bit, at least 4 |
| cfg_width_i | input | 4 | Data bit count, clamped to 5..9 |
| cfg_msb_first_i | input | 1 | 1: most significant data bit arrives first |
| cfg_parity_i | input | 3 | Parity rule code (see R6) |
| cfg_parity_check_i | input | 1 | 1: report parity mismatches |
| cfg_invert_i | input | 1 | 1: complement the line |
| rx_data_o | output | MAX_BITS | Received word, right-justified |
| rx_valid_o | output | 1 | One-cycle pulse: new word on rx_data_o |
| err_start_o | output | 1 | One-cycle pulse: false start rejected |
| err_parity_o | output | 1 | One-cycle pulse: parity rule violated |
| err_stop_o | output | 1 | One-cycle pulse: stop bit read low |

## Verification
Settings capture and bit sampling can fall in the same cycle. A new width or order presented during a frame reaches the inputs while the receiver is taking data samples. The bench provokes this by switching the width to 5 and flipping the bit order right after the start bit of an 8-bit frame. It judges the outcome by requiring the delivered word, and the cycle of its valid pulse, to follow the settings present at the start edge. A second pairing is the parity error and word delivery inside one frame. Corrupted parity must still yield the correct word, with the error pulse landing exactly one period after the valid pulse.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int WSEL_W = 4;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parity_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [WSEL_W-1:0] width;
    logic              msb_first;
    parity_mode_e      parity;
    logic              check;
  } frame_cfg_t;

endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic invert_i,
  output logic level_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // Inversion sits ahead of the synchronizer so a polarity change and a
  // matching line change reach the edge detector as one steady level.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i ^ invert_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign fall_o  = prev_q & ~level_o;

endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer #(
  parameter int PERIOD_W = 16,
  parameter int CNT_W    = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;

  assign hit_o = run_i && (cnt_q == tgt_q);

  // Targets are absolute offsets from the frame start: half a period,
  // then one whole period added per slot, all in exact integers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (launch_i) begin
      cnt_q <= CNT_W'(1);
      tgt_q <= CNT_W'(period_i >> 1);
    end else if (run_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (hit_o) tgt_q <= tgt_q + CNT_W'(period_i);
    end
  end

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import async_rx_pkg::*;
#(
  parameter int MAX_BITS = 9,
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                level_i,
  input  logic                hit_i,
  input  logic [PERIOD_W-1:0] cfg_period_i,
  input  logic [WSEL_W-1:0]   cfg_width_i,
  input  logic                cfg_msb_first_i,
  input  logic [2:0]          cfg_parity_i,
  input  logic                cfg_parity_check_i,
  output logic                launch_o,
  output logic                busy_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [WSEL_W-1:0]   width_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                err_start_o,
  output logic                err_parity_o,
  output logic                err_stop_o
);

  localparam int MIN_BITS = 5;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  function automatic logic [WSEL_W-1:0] clamp_width(input logic [WSEL_W-1:0] w);
    if (w < WSEL_W'(MIN_BITS)) return WSEL_W'(MIN_BITS);
    if (w > WSEL_W'(MAX_BITS)) return WSEL_W'(MAX_BITS);
    return w;
  endfunction

  function automatic parity_mode_e decode_parity(input logic [2:0] code);
    case (code)
      3'd1:    return PAR_ODD;
      3'd2:    return PAR_EVEN;
      3'd3:    return PAR_ZERO;
      3'd4:    return PAR_ONE;
      default: return PAR_NONE;
    endcase
  endfunction

  rx_state_e             state_q;
  frame_cfg_t            cfg_q;
  frame_cfg_t            cfg_in;
  logic [PERIOD_W-1:0]   period_q;
  logic [MAX_BITS-1:0]   word_q;
  logic [MAX_BITS-1:0]   word_next;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      top_idx;
  logic                  ones_odd;
  logic                  par_ok;
  logic                  idle;

  assign idle     = (state_q == ST_IDLE);
  assign launch_o = idle && fall_i;
  assign busy_o   = !idle;
  assign period_o = idle ? cfg_period_i : period_q;
  assign width_o  = cfg_q.width;
  assign top_idx  = IDX_W'(cfg_q.width - WSEL_W'(1));

  always_comb begin
    cfg_in.width     = clamp_width(cfg_width_i);
    cfg_in.msb_first = cfg_msb_first_i;
    cfg_in.parity    = decode_parity(cfg_parity_i);
    cfg_in.check     = cfg_parity_check_i;
  end

  always_comb begin
    if (cfg_q.msb_first) begin
      word_next = {word_q[MAX_BITS-2:0], level_i};
    end else begin
      word_next          = word_q >> 1;
      word_next[top_idx] = level_i;
    end
  end

  always_comb begin
    ones_odd = (^word_q) ^ level_i;
    case (cfg_q.parity)
      PAR_ODD:  par_ok = ones_odd;
      PAR_EVEN: par_ok = !ones_odd;
      PAR_ZERO: par_ok = !level_i;
      PAR_ONE:  par_ok = level_i;
      default:  par_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cfg_q        <= '0;
      period_q     <= '0;
      word_q       <= '0;
      idx_q        <= '0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      err_start_o  <= 1'b0;
      err_parity_o <= 1'b0;
      err_stop_o   <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      err_start_o  <= 1'b0;
      err_parity_o <= 1'b0;
      err_stop_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          cfg_q    <= cfg_in;
          period_q <= cfg_period_i;
          if (fall_i) state_q <= ST_START;
        end
        ST_START: if (hit_i) begin
          if (level_i) begin
            err_start_o <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            word_q  <= '0;
            idx_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (hit_i) begin
          word_q <= word_next;
          idx_q  <= idx_q + IDX_W'(1);
          if (idx_q == top_idx) begin
            data_o  <= word_next;
            valid_o <= 1'b1;
            state_q <= (cfg_q.parity == PAR_NONE) ? ST_STOP : ST_PARITY;
          end
        end
        ST_PARITY: if (hit_i) begin
          if (cfg_q.check && !par_ok) err_parity_o <= 1'b1;
          state_q <= ST_STOP;
        end
        ST_STOP: if (hit_i) begin
          if (!level_i) err_stop_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx
  import async_rx_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic [PERIOD_W-1:0] cfg_period_i,
  input  logic [WSEL_W-1:0]   cfg_width_i,
  input  logic                cfg_msb_first_i,
  input  logic [2:0]          cfg_parity_i,
  input  logic                cfg_parity_check_i,
  input  logic                cfg_invert_i,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                err_start_o,
  output logic                err_parity_o,
  output logic                err_stop_o
);

  // start + data + parity + stop slots bound the largest target
  localparam int SLOT_MAX = MAX_BITS + 3;
  localparam int CNT_W    = PERIOD_W + $clog2(SLOT_MAX + 1);

  logic                line_level;
  logic                line_fall;
  logic                slot_hit;
  logic                frame_launch;
  logic                frame_busy;
  logic [PERIOD_W-1:0] frame_period;
  logic [WSEL_W-1:0]   frame_width;

  rx_line_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_i),
    .invert_i (cfg_invert_i),
    .level_o  (line_level),
    .fall_o   (line_fall)
  );

  rx_slot_timer #(
    .PERIOD_W(PERIOD_W),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (frame_launch),
    .run_i    (frame_busy),
    .period_i (frame_period),
    .hit_o    (slot_hit)
  );

  rx_frame_engine #(
    .MAX_BITS(MAX_BITS),
    .PERIOD_W(PERIOD_W)
  ) u_engine (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .fall_i             (line_fall),
    .level_i            (line_level),
    .hit_i              (slot_hit),
    .cfg_period_i       (cfg_period_i),
    .cfg_width_i        (cfg_width_i),
    .cfg_msb_first_i    (cfg_msb_first_i),
    .cfg_parity_i       (cfg_parity_i),
    .cfg_parity_check_i (cfg_parity_check_i),
    .launch_o           (frame_launch),
    .busy_o             (frame_busy),
    .period_o           (frame_period),
    .width_o            (frame_width),
    .data_o             (rx_data_o),
    .valid_o            (rx_valid_o),
    .err_start_o        (err_start_o),
    .err_parity_o       (err_parity_o),
    .err_stop_o         (err_stop_o)
  );

endmodule

// File: rtl/async_frame_rx_chk.sv
module async_frame_rx_chk #(
  parameter int MAX_BITS = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                valid,
  input logic                e_start,
  input logic                e_parity,
  input logic                e_stop,
  input logic [MAX_BITS-1:0] data,
  input logic                busy,
  input logic                fall,
  input logic [3:0]          width
);

  // R1: a frame opens only after the line front reported a falling edge
  assert_open_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fall));

  // R2: the word strobe lasts exactly one cycle
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R3: a false start leaves the receiver idle
  assert_false_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    e_start |-> !busy);

  // R4: nothing above the active width is ever set
  assert_word_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((data >> width) == '0));

  // R7: a parity failure does not end the frame
  assert_parity_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    e_parity |-> busy);

  // R8: a low stop bit still completes the frame
  assert_stop_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    e_stop |-> !busy);

  // R10: the frame's width is held while it is in flight
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(width));

  // R4: an active frame always runs with a legal width
  assert_width_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (width >= 4'd5 && width <= 4'd9));

  // R7: strobes belong to distinct slots and never coincide
  assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid, e_start, e_parity, e_stop}));

endmodule

bind async_frame_rx async_frame_rx_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .valid    (rx_valid_o),
  .e_start  (err_start_o),
  .e_parity (err_parity_o),
  .e_stop   (err_stop_o),
  .data     (rx_data_o),
  .busy     (frame_busy),
  .fall     (line_fall),
  .width    (frame_width)
);

// File: tb/sim_async_frame_rx.sv
module sim_async_frame_rx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_P      = 8;
  localparam int NV         = 11;

  // {width[20:17], msb[16], parity[15:13], check[12], invert[11],
  //  flip_parity[10], stop_level[9], value[8:0]}
  localparam logic [20:0] VECS [NV] = '{
    {4'd8,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h0A5},
    {4'd8,  1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h03C},
    {4'd5,  1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h013},
    {4'd7,  1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 9'h055},
    {4'd9,  1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 9'h1A7},
    {4'd6,  1'b0, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 9'h02D},
    {4'd8,  1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0C3},
    {4'd9,  1'b1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 9'h101},
    {4'd8,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h07E},
    {4'd15, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1FF},
    {4'd3,  1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h015}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b0;
  logic [15:0] cfg_period = 16'(BIT_P);
  logic [3:0]  cfg_width = 4'd8;
  logic        cfg_msb = 1'b0;
  logic [2:0]  cfg_par = 3'd0;
  logic        cfg_chk = 1'b1;
  logic        cfg_inv = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, e_start, e_par, e_stop;

  int n_checks = 0, n_errors = 0, cyc = 0;
  int nv = 0, ns = 0, np = 0, nst = 0;
  int v_cyc = 0, s_cyc = 0, p_cyc = 0, st_cyc = 0, last_data = 0;
  bit done = 1'b0;

  async_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .cfg_period_i(cfg_period), .cfg_width_i(cfg_width),
    .cfg_msb_first_i(cfg_msb), .cfg_parity_i(cfg_par),
    .cfg_parity_check_i(cfg_chk), .cfg_invert_i(cfg_inv),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .err_start_o(e_start), .err_parity_o(e_par), .err_stop_o(e_stop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_valid) begin nv++; v_cyc = cyc; last_data = int'(rx_data); end
    if (e_start) begin ns++; s_cyc = cyc; end
    if (e_par)   begin np++; p_cyc = cyc; end
    if (e_stop)  begin nst++; st_cyc = cyc; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nv = 0; ns = 0; np = 0; nst = 0;
  endtask

  task automatic drive(input bit logical, input int cycles);
    rx = logical ^ cfg_inv;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic run_frame(input int w_in, input bit msb, input int pm_in,
                           input bit chk, input bit inv, input bit flip,
                           input bit stp, input int val, input int per,
                           input bit mid, input string tag);
    int n, pm, data, k, t0, exp_stop;
    bit pbit, p_err;
    n  = (w_in < 5) ? 5 : ((w_in > 9) ? 9 : w_in);
    pm = (pm_in > 4) ? 0 : pm_in;
    data = val & ((1 << n) - 1);
    @(negedge clk);
    cfg_width = 4'(w_in); cfg_msb = msb; cfg_par = 3'(pm_in);
    cfg_chk = chk; cfg_inv = inv; cfg_period = 16'(per);
    drive(1'b1, 3 * per + 4);
    clear_mon();
    k = cyc;
    drive(1'b0, per);
    if (mid) begin cfg_width = 4'd5; cfg_msb = ~msb; end
    for (int i = 0; i < n; i++) begin
      drive(1'((data >> (msb ? (n - 1 - i) : i)) & 1), per);
    end
    if (pm != 0) begin
      pbit = ^(9'(data));
      case (pm)
        1: pbit = ~pbit;
        3: pbit = 1'b0;
        4: pbit = 1'b1;
        default: ;
      endcase
      drive(pbit ^ flip, per);
    end
    drive(stp, per);
    drive(1'b1, 2 * per);
    t0 = k + 3 + per / 2;
    p_err = chk && (pm != 0) && flip;
    exp_stop = t0 + (n + 1 + ((pm != 0) ? 1 : 0)) * per;
    check(nv == 1, "R2", {tag, " word count"}, nv, 1);
    check(last_data == data, "R4 R5 R9", {tag, " word value"}, last_data, data);
    check(v_cyc == t0 + n * per, "R2", {tag, " valid cycle"}, v_cyc, t0 + n * per);
    check(np == int'(p_err), "R6 R7", {tag, " parity error count"}, np, int'(p_err));
    if (p_err)
      check(p_cyc == v_cyc + per, "R7", {tag, " parity error cycle"}, p_cyc, v_cyc + per);
    check(nst == int'(!stp), "R8", {tag, " stop error count"}, nst, int'(!stp));
    if (!stp)
      check(st_cyc == exp_stop, "R11", {tag, " stop error cycle"}, st_cyc, exp_stop);
    check(ns == 0, "R3", {tag, " no start error"}, ns, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rx_valid == 0 && e_start == 0 && e_par == 0 && e_stop == 0,
          "R1", "strobes after reset", int'({rx_valid, e_start, e_par, e_stop}), 0);
    check(rx_data == 0, "R1", "data after reset", int'(rx_data), 0);
    // R1: line low since reset starts nothing, nor does a rising edge
    clear_mon();
    repeat (4 * BIT_P) @(negedge clk);
    check(nv + ns + np + nst == 0, "R1", "low line from reset", nv + ns + np + nst, 0);
    rx = 1'b1;
    repeat (3 * BIT_P) @(negedge clk);
    check(nv + ns + np + nst == 0, "R1", "rising edge", nv + ns + np + nst, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_frame(int'(VECS[i][20:17]), VECS[i][16], int'(VECS[i][15:13]),
                VECS[i][12], VECS[i][11], VECS[i][10], VECS[i][9],
                int'(VECS[i][8:0]), BIT_P, 1'b0, $sformatf("vec%0d", i));
    end

    // R3: short low glitch is a false start, then a normal frame follows
    begin
      int k;
      @(negedge clk);
      cfg_inv = 1'b0; cfg_par = 3'd0; cfg_width = 4'd8; cfg_period = 16'(BIT_P);
      drive(1'b1, 3 * BIT_P);
      clear_mon();
      k = cyc;
      drive(1'b0, 2);
      drive(1'b1, 3 * BIT_P);
      check(ns == 1, "R3", "false start count", ns, 1);
      check(s_cyc == k + 3 + BIT_P / 2, "R3", "false start cycle", s_cyc, k + 3 + BIT_P / 2);
      check(nv == 0, "R3", "no word after false start", nv, 0);
    end
    run_frame(8, 0, 0, 1, 0, 0, 1, 'h96, BIT_P, 1'b0, "R3 recovery");

    // R2: odd divisor timing
    run_frame(8, 0, 2, 1, 0, 0, 1, 'h5A, 11, 1'b0, "R2 period11");
    // R10: settings changed mid-frame
    run_frame(8, 0, 0, 1, 0, 0, 1, 'hB4, BIT_P, 1'b1, "R10 midchange");
    // R10: the new settings take effect on the next frame
    run_frame(5, 1, 0, 1, 0, 0, 1, 'h0B, BIT_P, 1'b0, "R10 next frame");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule